// File: doc/BRIEF.md
# Bank Auto-Precharge Timing Tracker

This block follows the life of one bank of a DDR2-class memory device from the controller's side. It sees the Activate strobe and any column command (read or write) sent to its bank, together with the auto-precharge flag that goes with the column command. From these it works out the cycle in which the device begins its own internal precharge. It then keeps a single ready output that tells a scheduler when a fresh Activate to the same bank is legal.

The precharge start is the latest of two points. The first is the burst-derived point: read-to-precharge or write-recovery. The second is the minimum active time measured from the bank's Activate. The precharge period is counted from that start. The row cycle time measured from the last Activate must also be met before the bank may be opened again. All timing values are clock counts taken from configuration inputs. They must be held stable while the bank is in use. Commands that break protocol are dropped, and they set a flag that stays set until reset.

Top module: `bank_ap_tracker`

## Requirements
- R1: After reset the bank is closed, `act_ok_o` is 1, `pre_start_o` is 0 and `proto_err_o` is 0.
- R2: An Activate accepted in cycle a (it is the only strobe and `act_ok_o` is 1) makes `bank_open_o` 1 from cycle a+1.
- R3: A read or write with `ap_i`=0 leaves the bank open. It never produces `pre_start_o`.
- R4: With `cfg_bl8_i`=0 (burst of four), a read with `ap_i`=1 in cycle r raises `pre_start_o` in cycle r + AL + max(2, tRTP), provided the active-time minimum is already met.
- R5: With `cfg_bl8_i`=1 (burst of eight), the read precharge start is cycle r + AL + 2 + max(2, tRTP).
- R6: The precharge never starts before cycle a + tRAS, where a is the Activate cycle. A later tRAS point replaces the burst-derived cycle.
- R7: A write with `ap_i`=1 in cycle r starts precharge in cycle r + (AL + CL − 1) + BL/2 + tWR. BL/2 is 2 for a burst of four and 4 for a burst of eight. The tRAS point may push this later.
- R8: The bank reads closed from the cycle after `pre_start_o`. `act_ok_o` first returns to 1 in cycle P + tRP, where P is the precharge start cycle.
- R9: `act_ok_o` stays 0 until cycle a + tRC, even when tRP has already run out.
- R10: `proto_err_o` is set and stays set if any of these arrives: a column command while the bank is closed, a column command while an auto-precharge is pending, an Activate while `act_ok_o` is 0, or more than one strobe in the same cycle. The offending command has no effect on the bank.
- R11: Each accepted auto-precharge command yields exactly one single-cycle `pre_start_o` pulse, and the bank is open during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| act_i | input | 1 | Activate strobe for this bank |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ap_i | input | 1 | Auto-precharge flag sampled with rd_i or wr_i |
| cfg_al_i | input | TW | Additive latency, clocks |
| cfg_cl_i | input | TW | Read latency, clocks (at least 2) |
| cfg_bl8_i | input | 1 | 1 = burst of eight, 0 = burst of four |
| cfg_tras_i | input | TW | Minimum active time, clocks |
| cfg_trtp_i | input | TW | Read to precharge, clocks |
| cfg_twr_i | input | TW | Write recovery, clocks |
| cfg_trp_i | input | TW | Precharge period, clocks |
| cfg_trc_i | input | TW | Row cycle time, clocks |
| bank_open_o | output | 1 | Bank holds an open row |
| pre_start_o | output | 1 | Internal precharge starts in this cycle |
| act_ok_o | output | 1 | An Activate is legal in this cycle |
| proto_err_o | output | 1 | Sticky protocol violation flag |

## Verification
The bench pushes each timing bound so that it is the binding one in turn. These are the read-to-precharge floor of two clocks, a longer tRTP, the burst-of-eight offset, write recovery, and a tRAS long enough to override them. A tracker that takes the wrong maximum would pulse early, and one that counted the burst offset from the wrong point would be off by two. The bench also checks the gap from the pulse to the Activate window and a case where tRC rather than tRP gates reopening. A design counting tRP from the command instead would reopen too soon. Illegal commands are sent while the bank is closed, while a precharge is pending and as double strobes. A design that obeyed them would open the bank or add a second pulse.

// File: rtl/bank_ap_pkg.sv
package bank_ap_pkg;

   typedef enum logic [1:0] {
      TMR_RAS = 2'd0,
      TMR_RC  = 2'd1,
      TMR_RP  = 2'd2,
      TMR_AP  = 2'd3
   } tmr_e;

   localparam int NUM_TMR = 4;

   typedef struct packed {
      logic act_go;
      logic col_go;
      logic col_ap;
      logic col_wr;
      logic viol;
   } cmd_res_t;

endpackage

// File: rtl/bank_ap_cmd_check.sv
module bank_ap_cmd_check
   import bank_ap_pkg::*;
(
   input  logic     act_i,
   input  logic     rd_i,
   input  logic     wr_i,
   input  logic     ap_i,
   input  logic     open_i,
   input  logic     pend_i,
   input  logic     act_ok_i,
   output cmd_res_t res_o
);
   logic [1:0] n_strobe;
   logic       multi;
   logic       col;

   always_comb begin
      n_strobe     = {1'b0, act_i} + {1'b0, rd_i} + {1'b0, wr_i};
      multi        = (n_strobe > 2'd1);
      col          = rd_i | wr_i;
      res_o.act_go = act_i & ~multi & act_ok_i;
      res_o.col_go = col & ~multi & open_i & ~pend_i;
      res_o.col_ap = res_o.col_go & ap_i;
      res_o.col_wr = wr_i;
      res_o.viol   = multi
                   | (act_i & ~act_ok_i)
                   | (col & (~open_i | pend_i));
   end
endmodule

// File: rtl/bank_ap_delay.sv
module bank_ap_delay #(
   parameter int TW     = 6,
   parameter int DW     = TW + 3,
   parameter bit BL8_EN = 1'b1
) (
   input  logic          is_wr_i,
   input  logic          bl8_i,
   input  logic [TW-1:0] al_i,
   input  logic [TW-1:0] cl_i,
   input  logic [TW-1:0] trtp_i,
   input  logic [TW-1:0] twr_i,
   output logic [DW-1:0] dly_m1_o
);
   localparam int PADW = DW - TW;

   logic          bl8_eff;
   logic [DW-1:0] al_x, cl_x, trtp_x, twr_x;
   logic [DW-1:0] rtp_floor, rd_dly, wr_dly, dly;

   generate
      if (BL8_EN) begin : g_bl8
         assign bl8_eff = bl8_i;
      end else begin : g_bl4_only
         assign bl8_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      al_x      = {{PADW{1'b0}}, al_i};
      cl_x      = {{PADW{1'b0}}, cl_i};
      trtp_x    = {{PADW{1'b0}}, trtp_i};
      twr_x     = {{PADW{1'b0}}, twr_i};
      rtp_floor = (trtp_x > DW'(2)) ? trtp_x : DW'(2);
      rd_dly    = al_x + (bl8_eff ? DW'(2) : DW'(0)) + rtp_floor;
      wr_dly    = al_x + cl_x - DW'(1) + (bl8_eff ? DW'(4) : DW'(2)) + twr_x;
      dly       = is_wr_i ? wr_dly : rd_dly;
      dly_m1_o  = dly - DW'(1);
   end
endmodule

// File: rtl/bank_ap_timer.sv
module bank_ap_timer #(
   parameter int DW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [DW-1:0] ld_val_i,
   output logic          zero_o
);
   logic [DW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load_i)          cnt_q <= ld_val_i;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/bank_ap_tracker.sv
module bank_ap_tracker
   import bank_ap_pkg::*;
#(
   parameter int TW     = 6,
   parameter bit BL8_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_i,
   input  logic          rd_i,
   input  logic          wr_i,
   input  logic          ap_i,
   input  logic [TW-1:0] cfg_al_i,
   input  logic [TW-1:0] cfg_cl_i,
   input  logic          cfg_bl8_i,
   input  logic [TW-1:0] cfg_tras_i,
   input  logic [TW-1:0] cfg_trtp_i,
   input  logic [TW-1:0] cfg_twr_i,
   input  logic [TW-1:0] cfg_trp_i,
   input  logic [TW-1:0] cfg_trc_i,
   output logic          bank_open_o,
   output logic          pre_start_o,
   output logic          act_ok_o,
   output logic          proto_err_o
);
   localparam int DW   = TW + 3;
   localparam int PADW = DW - TW;

   generate
      if (TW < 2) begin : g_bad_tw
         $error("bank_ap_tracker: TW must be at least 2");
      end
   endgenerate

   function automatic logic [DW-1:0] sat_m1(input logic [TW-1:0] v);
      return (v == '0) ? '0 : ({{PADW{1'b0}}, v} - DW'(1));
   endfunction

   cmd_res_t              cmd;
   logic                  open_q, pend_q, err_q;
   logic [DW-1:0]         dly_m1;
   logic [NUM_TMR-1:0]    tmr_load, tmr_zero;
   logic [DW-1:0]         tmr_val [NUM_TMR];
   logic                  pre_now, act_ok;

   assign pre_now = pend_q & tmr_zero[TMR_AP] & tmr_zero[TMR_RAS];
   assign act_ok  = ~open_q & ~pend_q & tmr_zero[TMR_RP] & tmr_zero[TMR_RC];

   bank_ap_cmd_check u_chk (
      .act_i    (act_i),
      .rd_i     (rd_i),
      .wr_i     (wr_i),
      .ap_i     (ap_i),
      .open_i   (open_q),
      .pend_i   (pend_q),
      .act_ok_i (act_ok),
      .res_o    (cmd)
   );

   bank_ap_delay #(.TW(TW), .DW(DW), .BL8_EN(BL8_EN)) u_dly (
      .is_wr_i  (cmd.col_wr),
      .bl8_i    (cfg_bl8_i),
      .al_i     (cfg_al_i),
      .cl_i     (cfg_cl_i),
      .trtp_i   (cfg_trtp_i),
      .twr_i    (cfg_twr_i),
      .dly_m1_o (dly_m1)
   );

   always_comb begin
      tmr_load[TMR_RAS] = cmd.act_go;
      tmr_val[TMR_RAS]  = sat_m1(cfg_tras_i);
      tmr_load[TMR_RC]  = cmd.act_go;
      tmr_val[TMR_RC]   = sat_m1(cfg_trc_i);
      tmr_load[TMR_RP]  = pre_now;
      tmr_val[TMR_RP]   = sat_m1(cfg_trp_i);
      tmr_load[TMR_AP]  = cmd.col_ap;
      tmr_val[TMR_AP]   = dly_m1;
   end

   generate
      for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
         bank_ap_timer #(.DW(DW)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (tmr_load[g]),
            .ld_val_i (tmr_val[g]),
            .zero_o   (tmr_zero[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         pend_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (cmd.act_go)      open_q <= 1'b1;
         else if (pre_now)    open_q <= 1'b0;
         if (cmd.col_ap)      pend_q <= 1'b1;
         else if (pre_now)    pend_q <= 1'b0;
         if (cmd.viol)        err_q  <= 1'b1;
      end
   end

   assign bank_open_o = open_q;
   assign pre_start_o = pre_now;
   assign act_ok_o    = act_ok;
   assign proto_err_o = err_q;

   AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i && act_ok_o && !rd_i && !wr_i) |=> bank_open_o); // R2
   AST_NOAP_NO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_start_o) |-> pend_q); // R3
   AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start_o |=> !bank_open_o); // R8
   AST_REOPEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_ok_o) |-> !bank_open_o); // R8
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err_o |=> proto_err_o); // R10
   AST_COL_CLOSED_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_i || wr_i) && !bank_open_o) |=> (proto_err_o && !bank_open_o)); // R10
   AST_PRE_IN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start_o |-> bank_open_o); // R11
   AST_PRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start_o |=> !pre_start_o); // R11
endmodule

// File: tb/bank_ap_tracker_test.sv
module bank_ap_tracker_test;
   localparam int TW     = 6;
   localparam time PERIOD = 10ns;
   localparam int NV     = 8;

   localparam int V_WR  [NV] = '{0, 0, 0, 0, 0, 1, 1, 1};
   localparam int V_BL8 [NV] = '{0, 0, 1, 1, 0, 0, 1, 0};
   localparam int V_AL  [NV] = '{0, 1, 2, 0, 0, 0, 1, 0};
   localparam int V_CL  [NV] = '{3, 3, 3, 3, 3, 3, 4, 2};
   localparam int V_RTP [NV] = '{2, 4, 2, 5, 2, 2, 2, 2};
   localparam int V_TWR [NV] = '{1, 1, 1, 1, 1, 3, 2, 1};
   localparam int V_RAS [NV] = '{1, 1, 1, 1, 12, 1, 1, 15};
   localparam int V_EXP [NV] = '{2, 5, 6, 7, 10, 7, 10, 13};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic act = 1'b0, rd = 1'b0, wr = 1'b0, ap = 1'b0;
   logic [TW-1:0] al = '0, cl = 6'd3, trtp = 6'd2, twr = 6'd1;
   logic [TW-1:0] tras = 6'd1, trp = 6'd3, trc = 6'd4;
   logic bl8 = 1'b0;
   logic bank_open, pre_start, act_ok, perr;

   int n_chk = 0;
   int n_err = 0;

   always #(PERIOD/2) clk = ~clk;

   bank_ap_tracker #(.TW(TW), .BL8_EN(1'b1)) uut (
      .clk (clk), .rst_n (rst_n),
      .act_i (act), .rd_i (rd), .wr_i (wr), .ap_i (ap),
      .cfg_al_i (al), .cfg_cl_i (cl), .cfg_bl8_i (bl8),
      .cfg_tras_i (tras), .cfg_trtp_i (trtp), .cfg_twr_i (twr),
      .cfg_trp_i (trp), .cfg_trc_i (trc),
      .bank_open_o (bank_open), .pre_start_o (pre_start),
      .act_ok_o (act_ok), .proto_err_o (perr)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic step(input logic a, input logic r, input logic w, input logic p);
      @(negedge clk);
      act = a; rd = r; wr = w; ap = p;
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      act = 0; rd = 0; wr = 0; ap = 0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic wait_ok();
      for (int i = 0; i < 100 && !act_ok; i++) step(0, 0, 0, 0);
   endtask

   function automatic string vreq(input int i);
      case (i)
         0, 1:    return "R4";
         2, 3:    return "R5";
         4, 7:    return "R6";
         default: return "R7";
      endcase
   endfunction

   initial begin
      #(PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1", bank_open, 0);
      chk("R1", act_ok, 1);
      chk("R1", pre_start, 0);
      chk("R1", perr, 0);

      // table walk: activate, idle, AP command two cycles after activate
      for (int i = 0; i < NV; i++) begin
         int pre_at, ok_at, npre;
         al = V_AL[i]; cl = V_CL[i]; bl8 = V_BL8[i]; trtp = V_RTP[i];
         twr = V_TWR[i]; tras = V_RAS[i]; trp = 6'd3; trc = 6'd4;
         wait_ok();
         step(1, 0, 0, 0);
         step(0, 0, 0, 0);
         step(0, V_WR[i] == 0, V_WR[i] == 1, 1);
         pre_at = -1; ok_at = -1; npre = 0;
         for (int k = 1; k <= 60; k++) begin
            step(0, 0, 0, 0);
            if (pre_start) begin
               npre++;
               if (pre_at < 0) pre_at = k;
            end
            if (pre_at >= 0 && ok_at < 0 && act_ok) ok_at = k;
         end
         chk(vreq(i), pre_at, V_EXP[i]);
         chk("R8", ok_at - pre_at, 3);
         chk("R11", npre, 1);
      end
      chk("R10", perr, 0);

      // R2 / R3: plain column commands keep the bank open
      do_reset();
      al = 0; cl = 3; bl8 = 0; trtp = 2; twr = 1; tras = 1; trp = 3; trc = 4;
      step(1, 0, 0, 0);
      step(0, 0, 0, 0);
      chk("R2", bank_open, 1);
      step(0, 1, 0, 0);
      step(0, 0, 1, 0);
      begin
         int npre = 0;
         for (int k = 0; k < 20; k++) begin
            step(0, 0, 0, 0);
            if (pre_start) npre++;
         end
         chk("R3", npre, 0);
         chk("R3", bank_open, 1);
         chk("R3", act_ok, 0);
      end
      // R10 activate on open bank is rejected
      step(1, 0, 0, 0);
      step(0, 0, 0, 0);
      chk("R10", perr, 1);
      chk("R10", bank_open, 1);

      // R9 tRC dominates reopening
      do_reset();
      trc = 6'd20;
      step(1, 0, 0, 0);
      step(0, 1, 0, 1);
      begin
         int ok_at = -1;
         for (int k = 2; k <= 40; k++) begin
            step(0, 0, 0, 0);
            if (ok_at < 0 && act_ok) ok_at = k;
         end
         chk("R9", ok_at, 20);
      end
      trc = 6'd4;

      // R10 column command while closed
      do_reset();
      step(0, 1, 0, 1);
      begin
         int npre = 0;
         for (int k = 0; k < 10; k++) begin
            step(0, 0, 0, 0);
            if (pre_start) npre++;
         end
         chk("R10", perr, 1);
         chk("R10", bank_open, 0);
         chk("R10", npre, 0);
      end

      // R10 double strobe
      do_reset();
      step(1, 1, 0, 0);
      step(0, 0, 0, 0);
      chk("R10", perr, 1);
      chk("R10", bank_open, 0);

      // R10 / R11 second AP command while one is pending
      do_reset();
      step(1, 0, 0, 0);
      step(0, 0, 0, 0);
      step(0, 1, 0, 1);
      begin
         int pre_at = -1, npre = 0;
         step(0, 1, 0, 1);
         if (pre_start) begin npre++; pre_at = 1; end
         for (int k = 2; k <= 20; k++) begin
            step(0, 0, 0, 0);
            if (pre_start) begin
               npre++;
               if (pre_at < 0) pre_at = k;
            end
         end
         chk("R10", perr, 1);
         chk("R11", npre, 1);
         chk("R4", pre_at, 2);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule